// File: doc/BRIEF.md
# Programmable Resource Counter Bank

This block keeps sixteen 32-bit activity counters for performance measurement. Software chooses the source of each counter. A counter can tick on every clock cycle, tick on each rising edge of one line of an external event vector, or advance only when software asks it to through a register write. Counters are grouped for control by bit masks. One register turns counters on, another turns them off, and a third clears them. In each of these masks a 1 bit acts on the matching counter and a 0 bit leaves it alone.

Every counter has a shadow copy. A snapshot request comes either from a register write or from the dedicated request input that a trace-record builder drives. It copies all live counters into their shadows on the same clock edge. Software reads and trace appends then see one coherent set of values while counting goes on. All shadows are also exposed as one wide vector so that a record formatter can pick them up directly. Counters wrap silently. A sticky per-counter flag records that a rollover happened.

Top module: `rcb_bank`

## Requirements
- R1: After synchronous reset, all counters, shadows, enable bits and wrap flags are zero, every source select is 0 (clock), and the read data output is zero.
- R2: A counter whose select is 0 and whose enable bit is set adds 1 on every clock edge, starting with the edge after the enable write. The edge that applies a disable write still counts.
- R3: A select value of 2+k (k below the external vector width) makes the counter add 1 once per rising edge of external line k, judged between consecutive clock samples. A line held high counts once, and other lines are ignored.
- R4: A write to address 0x04 adds 1 to each enabled counter whose mask bit is 1. Select value 1, and any select value beyond the external range, gives a counter with no hardware source.
- R5: When a selected hardware event and a software increment hit the same counter on the same edge, the counter adds 2.
- R6: A write to 0x00 sets the enable bits given by 1s in the data, and a write to 0x01 clears them. 0 bits leave enables unchanged. A disabled counter holds its value and ignores all increments.
- R7: A write to 0x02 zeroes each counter whose mask bit is 1 and clears its wrap flag. This wins over any increment on that edge, and counters with 0 mask bits are unaffected.
- R8: A write to 0x03 or a high `snap_req_i` copies every counter's value from before that edge into its shadow, all on the same edge. Shadows change at no other time.
- R9: A read with `rd_en_i` high returns, on the next cycle, one of these values, and the output holds otherwise. Address 0x10+i gives shadow i, zero-extended. Address 0x05 gives the enable mask. Address 0x06 gives the wrap flags. Addresses 0x08 and 0x09 give the selects, 4 bits per counter, with counter j at bits 4*(j mod 8) of word 0x08 + j/8. Every other address reads zero.
- R10: A counter passing from all ones wraps to the low bits of the sum without any other effect. Its wrap flag is set by that rollover and stays set until the counter is cleared through 0x02.
- R11: `shadow_o` carries shadow i in bits [i*CNT_W +: CNT_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 6 | Register read address |
| rd_data_o | output | 32 | Registered read data, valid the cycle after the strobe |
| snap_req_i | input | 1 | Snapshot request from the trace path |
| ext_evt_i | input | EXT_W (8) | External event lines |
| shadow_o | output | 16*CNT_W (512) | All shadow registers side by side |

## Verification
The bench sets a disable write against a running clock counter. A design that stopped counting on that edge would come out one short. An external line held high for several cycles checks the edge detection, since a level-sensitive design would over-count. A hardware edge is made to land on the same cycle as a software increment, and a design that took only one of them would add 1 instead of 2. A clear is made to coincide with a hardware edge, which a design with the wrong priority would leave at 1. The bench uses a narrow counter so that rollover is reached. There it checks that the wrap flag rises only after the rollover, survives further counting and falls on a clear. Shadows are watched across later counting, because a shadow that tracked the live counter would drift.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

    localparam int NUM_CNT   = 16;
    localparam int SEL_W     = 4;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 6;
    localparam int SEL_BITS  = NUM_CNT * SEL_W;
    localparam int SEL_WORDS = SEL_BITS / DATA_W;

    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t ADR_EN_SET   = 6'h00;
    localparam addr_t ADR_EN_CLR   = 6'h01;
    localparam addr_t ADR_ZERO     = 6'h02;
    localparam addr_t ADR_SNAP     = 6'h03;
    localparam addr_t ADR_SWINC    = 6'h04;
    localparam addr_t ADR_EN_RD    = 6'h05;
    localparam addr_t ADR_WRAP_RD  = 6'h06;
    localparam addr_t ADR_SEL_BASE = 6'h08;
    localparam addr_t ADR_SHD_BASE = 6'h10;

    localparam logic [SEL_W-1:0] SEL_CLOCK    = 4'd0;
    localparam logic [SEL_W-1:0] SEL_SOFT     = 4'd1;
    localparam int               SEL_EXT_BASE = 2;

    typedef enum logic [1:0] {
        SRC_KIND_CLOCK,
        SRC_KIND_SOFT,
        SRC_KIND_EXT,
        SRC_KIND_NONE
    } src_kind_e;

    typedef struct packed {
        logic [NUM_CNT-1:0] en_set;
        logic [NUM_CNT-1:0] en_clr;
        logic [NUM_CNT-1:0] zero;
        logic [NUM_CNT-1:0] swinc;
        logic               snap;
    } ctl_cmd_t;

    function automatic src_kind_e classify_sel(logic [SEL_W-1:0] s, int ext_w);
        if (s == SEL_CLOCK)
            return SRC_KIND_CLOCK;
        else if (s == SEL_SOFT)
            return SRC_KIND_SOFT;
        else if (int'(s) < SEL_EXT_BASE + ext_w)
            return SRC_KIND_EXT;
        else
            return SRC_KIND_NONE;
    endfunction

endpackage

// File: rtl/rcb_regif.sv
module rcb_regif
    import rcb_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic                 snap_req_i,
    output ctl_cmd_t             cmd_o,
    output logic [NUM_CNT-1:0]   en_o,
    output logic [SEL_BITS-1:0]  sel_o
);

    logic [NUM_CNT-1:0]  en_q;
    logic [SEL_BITS-1:0] sel_q;

    // Decode one write into per-counter command masks.
    always_comb begin
        cmd_o = '0;
        if (wr_en_i && wr_addr_i == ADR_EN_SET) cmd_o.en_set = wr_data_i[NUM_CNT-1:0];
        if (wr_en_i && wr_addr_i == ADR_EN_CLR) cmd_o.en_clr = wr_data_i[NUM_CNT-1:0];
        if (wr_en_i && wr_addr_i == ADR_ZERO)   cmd_o.zero   = wr_data_i[NUM_CNT-1:0];
        if (wr_en_i && wr_addr_i == ADR_SWINC)  cmd_o.swinc  = wr_data_i[NUM_CNT-1:0];
        cmd_o.snap = snap_req_i | (wr_en_i && wr_addr_i == ADR_SNAP);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_q  <= '0;
            sel_q <= '0;
        end else begin
            en_q <= (en_q | cmd_o.en_set) & ~cmd_o.en_clr;
            for (int w = 0; w < SEL_WORDS; w++) begin
                if (wr_en_i && wr_addr_i == ADR_SEL_BASE + ADDR_W'(w))
                    sel_q[w*DATA_W +: DATA_W] <= wr_data_i;
            end
        end
    end

    assign en_o  = en_q;
    assign sel_o = sel_q;

endmodule

// File: rtl/rcb_src_sel.sv
module rcb_src_sel
    import rcb_pkg::*;
#(
    parameter int EXT_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [EXT_W-1:0]    ext_evt_i,
    input  logic [SEL_BITS-1:0] sel_i,
    output logic [NUM_CNT-1:0]  hit_o
);

    logic [EXT_W-1:0] ext_prev_q;
    logic [EXT_W-1:0] ext_rise;

    always_ff @(posedge clk_i) begin
        if (rst_i) ext_prev_q <= '0;
        else       ext_prev_q <= ext_evt_i;
    end

    assign ext_rise = ext_evt_i & ~ext_prev_q;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_src
        logic [SEL_W-1:0] s;
        src_kind_e        kind;
        logic             ext_hit;

        assign s    = sel_i[i*SEL_W +: SEL_W];
        assign kind = classify_sel(s, EXT_W);

        always_comb begin
            ext_hit = 1'b0;
            for (int k = 0; k < EXT_W; k++) begin
                if (s == SEL_W'(SEL_EXT_BASE + k)) ext_hit = ext_rise[k];
            end
        end

        always_comb begin
            unique case (kind)
                SRC_KIND_CLOCK: hit_o[i] = 1'b1;
                SRC_KIND_EXT:   hit_o[i] = ext_hit;
                default:        hit_o[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/rcb_counter.sv
module rcb_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             hw_hit_i,
    input  logic             sw_inc_i,
    input  logic             zero_i,
    input  logic             snap_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] shd_o,
    output logic             wrap_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] shd_q;
    logic             wrap_q;
    logic [1:0]       step;
    logic [CNT_W:0]   sum;

    always_comb begin
        step = {1'b0, hw_hit_i} + {1'b0, sw_inc_i};
        sum  = {1'b0, cnt_q} + (CNT_W+1)'(step);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= '0;
            shd_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            if (snap_i) shd_q <= cnt_q;
            if (zero_i) begin
                cnt_q  <= '0;
                wrap_q <= 1'b0;
            end else if (en_i) begin
                cnt_q <= sum[CNT_W-1:0];
                if (sum[CNT_W]) wrap_q <= 1'b1;
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign shd_o  = shd_q;
    assign wrap_o = wrap_q;

endmodule

// File: rtl/rcb_rdmux.sv
module rcb_rdmux
    import rcb_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                            clk_i,
    input  logic                            rst_i,
    input  logic                            rd_en_i,
    input  logic [ADDR_W-1:0]               rd_addr_i,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]   shd_i,
    input  logic [NUM_CNT-1:0]              en_i,
    input  logic [NUM_CNT-1:0]              wrap_i,
    input  logic [SEL_BITS-1:0]             sel_i,
    output logic [DATA_W-1:0]               rd_data_o
);

    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rd_q;

    always_comb begin
        rd_next = '0;
        if (rd_addr_i == ADR_EN_RD)   rd_next = DATA_W'(en_i);
        if (rd_addr_i == ADR_WRAP_RD) rd_next = DATA_W'(wrap_i);
        for (int w = 0; w < SEL_WORDS; w++) begin
            if (rd_addr_i == ADR_SEL_BASE + ADDR_W'(w))
                rd_next = sel_i[w*DATA_W +: DATA_W];
        end
        for (int i = 0; i < NUM_CNT; i++) begin
            if (rd_addr_i == ADR_SHD_BASE + ADDR_W'(i))
                rd_next = DATA_W'(shd_i[i]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)        rd_q <= '0;
        else if (rd_en_i) rd_q <= rd_next;
    end

    assign rd_data_o = rd_q;

endmodule

// File: rtl/rcb_bank.sv
module rcb_bank
    import rcb_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int EXT_W = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [DATA_W-1:0]          wr_data_i,
    input  logic                       rd_en_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    output logic [DATA_W-1:0]          rd_data_o,
    input  logic                       snap_req_i,
    input  logic [EXT_W-1:0]           ext_evt_i,
    output logic [NUM_CNT*CNT_W-1:0]   shadow_o
);

    ctl_cmd_t                      cmd;
    logic [NUM_CNT-1:0]            en_q;
    logic [SEL_BITS-1:0]           sel_q;
    logic [NUM_CNT-1:0]            hw_hit;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec;
    logic [NUM_CNT-1:0][CNT_W-1:0] shd_vec;
    logic [NUM_CNT-1:0]            wrap_vec;
    logic                          snap_w;
    logic [NUM_CNT-1:0]            zero_w;

    rcb_regif u_regif (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .snap_req_i (snap_req_i),
        .cmd_o      (cmd),
        .en_o       (en_q),
        .sel_o      (sel_q)
    );

    rcb_src_sel #(.EXT_W(EXT_W)) u_src (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ext_evt_i (ext_evt_i),
        .sel_i     (sel_q),
        .hit_o     (hw_hit)
    );

    assign snap_w = cmd.snap;
    assign zero_w = cmd.zero;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        rcb_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .en_i     (en_q[i]),
            .hw_hit_i (hw_hit[i]),
            .sw_inc_i (cmd.swinc[i]),
            .zero_i   (cmd.zero[i]),
            .snap_i   (cmd.snap),
            .cnt_o    (cnt_vec[i]),
            .shd_o    (shd_vec[i]),
            .wrap_o   (wrap_vec[i])
        );
    end

    rcb_rdmux #(.CNT_W(CNT_W)) u_rd (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .shd_i     (shd_vec),
        .en_i      (en_q),
        .wrap_i    (wrap_vec),
        .sel_i     (sel_q),
        .rd_data_o (rd_data_o)
    );

    assign shadow_o = shd_vec;

endmodule

// File: rtl/rcb_bank_chk.sv
module rcb_bank_chk
    import rcb_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                            clk,
    input logic                            rst,
    input logic [NUM_CNT-1:0][CNT_W-1:0]   cnt,
    input logic [NUM_CNT-1:0][CNT_W-1:0]   shd,
    input logic [NUM_CNT-1:0]              en,
    input logic [NUM_CNT-1:0]              wrap,
    input logic                            snap,
    input logic [NUM_CNT-1:0]              zero
);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
            (!en[i] && !zero[i]) |=> cnt[i] == $past(cnt[i])); // R6

        AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
            snap |=> shd[i] == $past(cnt[i])); // R8

        AST_SHADOW_STILL: assert property (@(posedge clk) disable iff (rst)
            !snap |=> $stable(shd[i])); // R8

        AST_ZERO_WINS: assert property (@(posedge clk) disable iff (rst)
            zero[i] |=> (cnt[i] == '0) && !wrap[i]); // R7

        AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (rst)
            (wrap[i] && !zero[i]) |=> wrap[i]); // R10

        AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (rst)
            (en[i] && !zero[i]) |=> CNT_W'(cnt[i] - $past(cnt[i])) <= CNT_W'(2)); // R5
    end

endmodule

bind rcb_bank rcb_bank_chk #(.CNT_W(CNT_W)) u_chk (
    .clk  (clk_i),
    .rst  (rst_i),
    .cnt  (cnt_vec),
    .shd  (shd_vec),
    .en   (en_q),
    .wrap (wrap_vec),
    .snap (snap_w),
    .zero (zero_w)
);

// File: tb/rcb_bank_tb_top.sv
`timescale 1ns/1ps
module rcb_bank_tb_top;

    localparam int CNT_W = 10;
    localparam int EXT_W = 8;
    localparam int NC    = 16;
    localparam int MAXV  = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [5:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              rd_en = 1'b0;
    logic [5:0]        rd_addr = '0;
    logic [31:0]       rd_data;
    logic              snap_req = 1'b0;
    logic [EXT_W-1:0]  ext = '0;
    logic [NC*CNT_W-1:0] shadow;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    rcb_bank #(.CNT_W(CNT_W), .EXT_W(EXT_W)) dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_en_i    (rd_en),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .snap_req_i (snap_req),
        .ext_evt_i  (ext),
        .shadow_o   (shadow)
    );

    // Behavioural reference model
    int         m_cnt[NC];
    int         m_shd[NC];
    int         m_sel[NC];
    bit         m_en[NC];
    bit         m_wrap[NC];
    bit [EXT_W-1:0] m_prev;
    logic [31:0] m_rd;

    function automatic logic [31:0] m_read(logic [5:0] a);
        logic [31:0] v = '0;
        if (a == 6'h05) for (int i = 0; i < NC; i++) v[i] = m_en[i];
        else if (a == 6'h06) for (int i = 0; i < NC; i++) v[i] = m_wrap[i];
        else if (a == 6'h08 || a == 6'h09) begin
            for (int j = 0; j < 8; j++) v[4*j +: 4] = 4'(m_sel[(a == 6'h09 ? 8 : 0) + j]);
        end else if (a >= 6'h10 && a < 6'h20) v = 32'(m_shd[a - 6'h10]);
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NC; i++) begin
                m_cnt[i] = 0; m_shd[i] = 0; m_sel[i] = 0; m_en[i] = 0; m_wrap[i] = 0;
            end
            m_prev = '0;
            m_rd   = '0;
        end else begin
            bit snap;
            if (rd_en) m_rd = m_read(rd_addr);
            snap = snap_req || (wr_en && wr_addr == 6'h03);
            for (int i = 0; i < NC; i++) begin
                int hit;
                int sw;
                int t;
                if (snap) m_shd[i] = m_cnt[i];
                hit = 0;
                if (m_sel[i] == 0) hit = 1;
                else if (m_sel[i] >= 2 && m_sel[i] < 2 + EXT_W)
                    hit = (ext[m_sel[i]-2] && !m_prev[m_sel[i]-2]) ? 1 : 0;
                sw = (wr_en && wr_addr == 6'h04 && wr_data[i]) ? 1 : 0;
                if (wr_en && wr_addr == 6'h02 && wr_data[i]) begin
                    m_cnt[i] = 0; m_wrap[i] = 0;
                end else if (m_en[i]) begin
                    t = m_cnt[i] + hit + sw;
                    if (t > MAXV) begin m_wrap[i] = 1; t = t - (MAXV + 1); end
                    m_cnt[i] = t;
                end
            end
            m_prev = ext;
            if (wr_en && wr_addr == 6'h00) for (int i = 0; i < NC; i++) if (wr_data[i]) m_en[i] = 1;
            if (wr_en && wr_addr == 6'h01) for (int i = 0; i < NC; i++) if (wr_data[i]) m_en[i] = 0;
            if (wr_en && wr_addr == 6'h08) for (int j = 0; j < 8; j++) m_sel[j]   = int'(wr_data[4*j +: 4]);
            if (wr_en && wr_addr == 6'h09) for (int j = 0; j < 8; j++) m_sel[8+j] = int'(wr_data[4*j +: 4]);
        end
    end

    // Every-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            int bad_i = -1;
            for (int i = 0; i < NC; i++)
                if (bad_i < 0 && shadow[i*CNT_W +: CNT_W] !== CNT_W'(m_shd[i])) bad_i = i;
            n_chk++;
            if (bad_i >= 0) begin
                n_bad++;
                $display("FAIL R8 R11 shadow %0d actual=%0h expected=%0h", bad_i,
                         shadow[bad_i*CNT_W +: CNT_W], m_shd[bad_i]);
            end
            n_chk++;
            if (rd_data !== m_rd) begin
                n_bad++;
                $display("FAIL R9 read data actual=%0h expected=%0h", rd_data, m_rd);
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] v);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v, v1, v2;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(6'h05, v); check("R1 enable mask", v, 32'h0);
        rd(6'h06, v); check("R1 wrap flags", v, 32'h0);
        rd(6'h08, v); check("R1 select word", v, 32'h0);
        check("R1 shadow vector", 32'(shadow == '0), 32'h1);

        // Selects: c2 software only, c4 external line 1, rest clock
        wr(6'h08, 32'h0003_0100);
        rd(6'h08, v); check("R9 select readback", v, 32'h0003_0100);

        // R4: software increments, R6: disabled counter ignores them
        wr(6'h00, 32'h4);
        repeat (3) wr(6'h04, 32'h4);
        wr(6'h04, 32'h8);
        wr(6'h03, 32'h0);
        rd(6'h12, v); check("R4 software count", v, 32'd3);
        rd(6'h13, v); check("R6 disabled ignores increment", v, 32'd0);

        // R2: clock source, disable edge still counts
        wr(6'h00, 32'h1);
        idle(20);
        wr(6'h01, 32'h1);
        wr(6'h03, 32'h0);
        rd(6'h10, v1); check("R2 clock count", v1, 32'd21);
        idle(10);
        wr(6'h03, 32'h0);
        rd(6'h10, v2); check("R6 disabled counter holds", v2, v1);

        // R3: external rising edges on line 1
        wr(6'h00, 32'h10);
        ext[1] = 1'b1; idle(3);
        ext = '0;      idle(2);
        ext[1] = 1'b1; ext[0] = 1'b1; idle(1);
        ext = '0;      idle(2);
        wr(6'h03, 32'h0);
        rd(6'h14, v); check("R3 external edge count", v, 32'd2);

        // R5: coincident hardware edge and software increment
        ext[1] = 1'b1;
        wr(6'h04, 32'h10);
        ext = '0; idle(2);
        wr(6'h03, 32'h0);
        rd(6'h14, v); check("R5 coincident adds two", v, 32'd4);

        // R7: clear wins over a coincident edge, others untouched
        ext[1] = 1'b1;
        wr(6'h02, 32'h10);
        ext = '0; idle(2);
        wr(6'h03, 32'h0);
        rd(6'h14, v); check("R7 cleared counter", v, 32'd0);
        rd(6'h12, v); check("R7 other counter kept", v, 32'd3);

        // R8, R11: snapshot through the request pin, shadow holds afterwards
        wr(6'h04, 32'h4);
        snap_req = 1'b1; @(negedge clk); snap_req = 1'b0;
        check("R11 shadow slice", 32'(shadow[2*CNT_W +: CNT_W]), 32'd4);
        wr(6'h04, 32'h4);
        idle(3);
        check("R8 shadow stays", 32'(shadow[2*CNT_W +: CNT_W]), 32'd4);
        rd(6'h12, v); check("R9 shadow read", v, 32'd4);

        // R9: unmapped and write-only addresses read zero
        rd(6'h3F, v); check("R9 unmapped reads zero", v, 32'h0);
        rd(6'h02, v); check("R9 command address reads zero", v, 32'h0);

        // R10: rollover and sticky wrap flag
        wr(6'h00, 32'h20);
        idle(10);
        rd(6'h06, v); check("R10 no wrap yet", 32'(v[5]), 32'h0);
        idle(1100);
        rd(6'h06, v); check("R10 wrap flag set", 32'(v[5]), 32'h1);
        idle(50);
        rd(6'h06, v); check("R10 wrap flag sticky", 32'(v[5]), 32'h1);
        wr(6'h03, 32'h0);
        idle(2);
        wr(6'h02, 32'h20);
        rd(6'h06, v); check("R7 clear drops wrap flag", 32'(v[5]), 32'h0);
        rd(6'h05, v); check("R6 enable mask", v, 32'h0000_0034);

        idle(2);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule